// File: doc/BRIEF.md
# Gated Dual Timer/Counter

This block holds two timer/counter channels that share one configuration byte. Each channel advances either once per machine-cycle strobe or on a falling edge seen at its external count pin. When gating is enabled, a channel counts only while its gate pin is high, so software can measure the length of a high pulse in machine cycles. Each channel can be set to one of four counting arrangements: a prescaled counter, a full double-byte counter, a single-byte counter that reloads itself, or a split arrangement. In the split arrangement channel 0 acts as two independent byte timers, and channel 1 freezes.

A simple register port writes and reads the configuration byte, the control byte and the four count bytes. The two overflow flags are also driven straight out as outputs, so an interrupt controller can watch them. The flags stay set until software writes them clear.

Top module: `gtc_pair`

## Requirements
- R1: After reset every register reads as zero and both overflow flags are low.
- R2: Register addresses: 0 is the configuration byte, 1 is the control byte, 2 and 3 are channel 0 low and high count bytes, 4 and 5 are channel 1 low and high count bytes. In the configuration byte, channel 0 uses bits 3:0 and channel 1 uses bits 7:4, each nibble laid out as {gate, external, mode[1:0]}. In the control byte, bit 0 is run0, bit 1 is run1, bit 2 is flag0 and bit 3 is flag1. All of these read back what was written, unless hardware has changed them since.
- R3: With external=0, an enabled channel advances by one on each cycle in which the machine-cycle strobe is high.
- R4: With external=1, the count pin is sampled on each strobe. A channel advances by one on the strobe after a sample of 1 has been followed by a sample of 0. A low level that no strobe samples is not counted.
- R5: A channel is enabled when its run bit is 1 and either its gate bit is 0 or its gate pin is high.
- R6: Mode 00: the high byte joined above the lowest PS_W bits of the low byte forms one counter. The upper bits of the low byte keep their value. When the joined value wraps to zero, the channel's flag is set.
- R7: Mode 01: the high and low bytes form one double-byte counter. When it wraps to zero, the channel's flag is set.
- R8: Mode 10: the low byte counts. An event that finds the low byte all ones loads the low byte from the high byte and sets the channel's flag.
- R9: Mode 11 on channel 0: the low byte counts under channel 0's own enable and source and sets flag0 when it wraps. The high byte counts strobes while run1 is set and sets flag1 when it wraps. A channel 1 set to mode 11 holds its count.
- R10: While channel 0 is in mode 11, a wrap of channel 1 does not set flag1.
- R11: A flag stays set until a control write puts 0 in it. If an overflow happens in the same cycle as that write, the flag ends up set.
- R12: A count-byte write loads the written byte in that cycle. In modes 00 and 01, a write to either byte cancels that channel's count step. In modes 10 and 11, a low-byte write cancels the low-byte step and a high-byte write cancels the split high timer. A reload in that cycle uses the old high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mc_tick | input | 1 | Machine-cycle strobe |
| cnt_pin | input | 2 | External count pins, one per channel |
| gate_pin | input | 2 | Gate level pins, one per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr |
| ovf_flag | output | 2 | Sticky overflow flags |

## Verification
The bench builds the block with DW=8 and PS_W=3. This shrinks the prescaled mode to an 11-bit counter, so a sweep of start points and a wrap through all ones fit in a few hundred strobes. Every reload value class in mode 10 is stepped past several wraps. Edge counting is driven from fixed bit patterns, with the expected count taken from the 1-to-0 transitions in each pattern. Writes that collide with strobes and flag clears that collide with overflows are each forced into a single cycle.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  typedef enum logic [1:0] {
    MD_PRESCALE = 2'b00,
    MD_WIDE     = 2'b01,
    MD_RELOAD   = 2'b10,
    MD_SPLIT    = 2'b11
  } gtc_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext;
    gtc_mode_e mode;
  } gtc_chcfg_t;

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_C0L  = 3'd2;
  localparam logic [2:0] A_C0H  = 3'd3;
  localparam logic [2:0] A_C1L  = 3'd4;
  localparam logic [2:0] A_C1H  = 3'd5;
endpackage

// File: rtl/gtc_pin_sampler.sv
module gtc_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall_evt
);
  logic s_new, s_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_new <= 1'b0;
      s_old <= 1'b0;
    end else if (tick) begin
      s_new <= pin;
      s_old <= s_new;
    end
  end

  assign fall_evt = tick & s_old & ~s_new;

  // R4
  fall_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt);
endmodule

// File: rtl/gtc_count_core.sv
module gtc_count_core
  import gtc_pkg::*;
#(
  parameter int DW   = 8,
  parameter int PS_W = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  gtc_mode_e     mode,
  input  logic          evt,
  input  logic          hi_evt,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] lo,
  output logic [DW-1:0] hi,
  output logic          ovf_main,
  output logic          ovf_hi
);
  localparam int PW = DW + PS_W;
  localparam int WW = 2 * DW;

  function automatic logic [PW-1:0] pre_join(input logic [DW-1:0] h,
                                             input logic [DW-1:0] l);
    return {h, l[PS_W-1:0]};
  endfunction

  function automatic logic [DW-1:0] byte_step(input logic [DW-1:0] v);
    return v + DW'(1);
  endfunction

  logic [DW-1:0] nlo, nhi;
  logic [PW-1:0] pre_cur;
  logic          wr_any;

  assign wr_any  = wr_lo | wr_hi;
  assign pre_cur = pre_join(hi, lo);

  always_comb begin
    nlo      = lo;
    nhi      = hi;
    ovf_main = 1'b0;
    ovf_hi   = 1'b0;
    case (mode)
      MD_PRESCALE: begin
        if (evt && !wr_any) begin
          {nhi, nlo[PS_W-1:0]} = pre_cur + PW'(1);
          ovf_main = &pre_cur;
        end
      end
      MD_WIDE: begin
        if (evt && !wr_any) begin
          {nhi, nlo} = {hi, lo} + WW'(1);
          ovf_main = &{hi, lo};
        end
      end
      MD_RELOAD: begin
        if (evt && !wr_lo) begin
          if (&lo) begin
            nlo      = hi;
            ovf_main = 1'b1;
          end else begin
            nlo = byte_step(lo);
          end
        end
      end
      default: begin
        if (evt && !wr_lo) begin
          nlo      = byte_step(lo);
          ovf_main = &lo;
        end
        if (hi_evt && !wr_hi) begin
          nhi    = byte_step(hi);
          ovf_hi = &hi;
        end
      end
    endcase
    if (wr_lo) nlo = wdata;
    if (wr_hi) nhi = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= nlo;
      hi <= nhi;
    end
  end

  // R12
  wr_lo_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> lo == $past(wdata));

  // R7
  wide_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_WIDE && evt && !wr_lo && !wr_hi)
      |=> {hi, lo} == $past({hi, lo}) + WW'(1));

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RELOAD && evt && !wr_lo && (&lo)) |=> lo == $past(hi));

  // R6
  pre_upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PRESCALE && !wr_lo) |=> lo[DW-1:PS_W] == $past(lo[DW-1:PS_W]));
endmodule

// File: rtl/gtc_pair.sv
module gtc_pair
  import gtc_pkg::*;
#(
  parameter int DW   = 8,
  parameter int PS_W = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mc_tick,
  input  logic [1:0]    cnt_pin,
  input  logic [1:0]    gate_pin,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [1:0]    ovf_flag
);
  localparam int NCH = 2;

  logic [7:0]    mode_q;
  logic [1:0]    run_q, ovf_q, ovf_set;
  gtc_chcfg_t    cfg [NCH];
  logic [NCH-1:0] en, evt, hi_evt, fall, ovm, ovh, wr_lo, wr_hi;
  logic [DW-1:0] c_lo [NCH];
  logic [DW-1:0] c_hi [NCH];
  logic          ctrl_wr, split0;

  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign split0  = (cfg[0].mode == MD_SPLIT);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic src;
    assign cfg[c]   = gtc_chcfg_t'(mode_q[4*c +: 4]);
    assign wr_lo[c] = reg_wr && (reg_addr == A_C0L + 3'(2*c));
    assign wr_hi[c] = reg_wr && (reg_addr == A_C0H + 3'(2*c));
    assign en[c]    = run_q[c] & (~cfg[c].gate | gate_pin[c]);

    gtc_pin_sampler u_smp (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (mc_tick),
      .pin      (cnt_pin[c]),
      .fall_evt (fall[c])
    );

    assign src = cfg[c].ext ? fall[c] : mc_tick;

    if (c == 0) begin : g_first
      assign evt[c]    = en[c] & src;
      assign hi_evt[c] = mc_tick & run_q[1] & split0;
    end else begin : g_other
      assign evt[c]    = en[c] & src & (cfg[c].mode != MD_SPLIT);
      assign hi_evt[c] = 1'b0;
    end

    gtc_count_core #(.DW(DW), .PS_W(PS_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (cfg[c].mode),
      .evt      (evt[c]),
      .hi_evt   (hi_evt[c]),
      .wr_lo    (wr_lo[c]),
      .wr_hi    (wr_hi[c]),
      .wdata    (reg_wdata),
      .lo       (c_lo[c]),
      .hi       (c_hi[c]),
      .ovf_main (ovm[c]),
      .ovf_hi   (ovh[c])
    );
  end

  assign ovf_set[0] = ovm[0];
  assign ovf_set[1] = split0 ? ovh[0] : (ovm[1] | ovh[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      ovf_q  <= '0;
    end else begin
      if (reg_wr && reg_addr == A_MODE) mode_q <= reg_wdata[7:0];
      if (ctrl_wr) begin
        run_q <= reg_wdata[1:0];
        ovf_q <= reg_wdata[3:2] | ovf_set;
      end else begin
        ovf_q <= ovf_q | ovf_set;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = DW'(mode_q);
      A_CTRL:  reg_rdata = DW'({ovf_q, run_q});
      A_C0L:   reg_rdata = c_lo[0];
      A_C0H:   reg_rdata = c_hi[0];
      A_C1L:   reg_rdata = c_lo[1];
      A_C1H:   reg_rdata = c_hi[1];
      default: reg_rdata = '0;
    endcase
  end

  assign ovf_flag = ovf_q;

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q[0] && !ctrl_wr) |=> ovf_q[0]);

  // R9
  ch1_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1].mode == MD_SPLIT && !wr_lo[1] && !wr_hi[1])
      |=> $stable({c_hi[1], c_lo[1]}));

  // R5
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[0].mode == MD_WIDE && cfg[0].gate && !gate_pin[0] && !wr_lo[0] && !wr_hi[0])
      |=> $stable({c_hi[0], c_lo[0]}));

  // R10
  split_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (split0 && !ovh[0] && !ovf_q[1] && !ctrl_wr) |=> !ovf_q[1]);
endmodule

// File: tb/tb_gtc_pair.sv
module tb_gtc_pair;
  localparam int DW   = 8;
  localparam int PS_W = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mc_tick = 1'b0;
  logic [1:0]    cnt_pin = 2'b00;
  logic [1:0]    gate_pin = 2'b00;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = 3'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [1:0]    ovf_flag;

  int total = 0;
  int bad = 0;

  gtc_pair #(.DW(DW), .PS_W(PS_W)) dut (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_flag(ovf_flag)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic step(input logic t);
    mc_tick = t;
    @(negedge clk);
    mc_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic t);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; mc_tick = t;
    @(negedge clk);
    reg_wr = 1'b0; mc_tick = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic rd16(input int ch, output int v);
    int l, h;
    rd(3'(2 + 2*ch), l);
    rd(3'(3 + 2*ch), h);
    v = (h << 8) | l;
  endtask

  function automatic int falls(input logic [31:0] p);
    int c = 0;
    logic prev = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (prev && !p[i]) c++;
      prev = p[i];
    end
    return c;
  endfunction

  function automatic int reload_model(input int start, input int r, input int k);
    int v = start;
    for (int i = 0; i < k; i++) v = (v == 255) ? r : v + 1;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    logic [31:0] pats [2];
    int rl [5];
    pats[0] = 32'hB3C5_0F69;
    pats[1] = 32'h5555_F00F;
    rl[0] = 0; rl[1] = 8'h80; rl[2] = 8'hF0; rl[3] = 8'hFE; rl[4] = 8'hFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk("R1 reset reg", v, 0);
    end
    chk("R1 flags", int'(ovf_flag), 0);

    // R2 register readback
    wr(3'd0, 8'hA5, 0); rd(3'd0, v); chk("R2 mode", v, 8'hA5);
    for (int a = 2; a < 6; a++) begin
      wr(3'(a), 8'(a * 17), 0); rd(3'(a), v); chk("R2 count byte", v, a * 17);
    end

    // R3 R7 wide timer wrap
    wr(3'd0, 8'h11, 0);
    wr(3'd2, 8'hF0, 0); wr(3'd3, 8'hFF, 0);
    wr(3'd4, 8'h00, 0); wr(3'd5, 8'h00, 0);
    wr(3'd1, 8'h01, 0);
    ticks(20);
    rd16(0, v); chk("R7 wide wrap count", v, 16'h0004);
    chk("R7 flag0", int'(ovf_flag[0]), 1);
    rd16(1, v); chk("R3 stopped channel", v, 0);

    // R11 sticky and clear
    ticks(5);
    rd(3'd1, v); chk("R11 sticky", v, 8'h05);
    wr(3'd1, 8'h01, 0);
    chk("R11 cleared", int'(ovf_flag[0]), 0);
    wr(3'd2, 8'hFF, 0); wr(3'd3, 8'hFF, 0);
    wr(3'd1, 8'h01, 1);
    chk("R11 set wins over clear", int'(ovf_flag[0]), 1);
    rd16(0, v); chk("R11 wrap during clear", v, 0);

    // R6 prescaled sweep
    wr(3'd0, 8'h10, 0);
    for (int n = 0; n <= 40; n += 3) begin
      wr(3'd2, 8'h00, 0); wr(3'd3, 8'h00, 0);
      ticks(n);
      rd16(0, v); chk("R6 prescale count", v, ((n >> PS_W) << 8) | (n & 7));
    end
    wr(3'd1, 8'h01, 0);
    wr(3'd2, 8'hA7, 0); wr(3'd3, 8'hFF, 0);
    ticks(1);
    rd16(0, v); chk("R6 upper bits kept at wrap", v, 16'h00A0);
    chk("R6 flag0", int'(ovf_flag[0]), 1);

    // R8 reload sweep
    wr(3'd0, 8'h12, 0);
    for (int j = 0; j < 5; j++) begin
      wr(3'd1, 8'h01, 0);
      wr(3'd3, 8'(rl[j]), 0); wr(3'd2, 8'hFD, 0);
      ticks(300);
      rd(3'd2, v); chk("R8 reload low", v, reload_model(8'hFD, rl[j], 300));
      rd(3'd3, v); chk("R8 reload high kept", v, rl[j]);
      chk("R8 flag0", int'(ovf_flag[0]), 1);
    end

    // R4 edge counting
    wr(3'd0, 8'h15, 0);
    for (int p = 0; p < 2; p++) begin
      cnt_pin[0] = 1'b1; ticks(2);
      wr(3'd2, 8'h00, 0); wr(3'd3, 8'h00, 0);
      for (int i = 0; i < 32; i++) begin
        cnt_pin[0] = pats[p][i]; step(1'b1);
      end
      ticks(2);
      rd16(0, v); chk("R4 falling edges", v, falls(pats[p]));
    end
    cnt_pin[0] = 1'b1; ticks(2);
    wr(3'd2, 8'h00, 0); wr(3'd3, 8'h00, 0);
    cnt_pin[0] = 1'b0; step(1'b0); cnt_pin[0] = 1'b1;
    ticks(3);
    rd16(0, v); chk("R4 unsampled low ignored", v, 0);

    // R5 gating on channel 1
    wr(3'd0, 8'h90, 0);
    wr(3'd1, 8'h02, 0);
    wr(3'd4, 8'h00, 0); wr(3'd5, 8'h00, 0);
    gate_pin[1] = 1'b0; ticks(10);
    rd16(1, v); chk("R5 gate low blocks", v, 0);
    gate_pin[1] = 1'b1; ticks(7);
    rd16(1, v); chk("R5 gate high counts", v, 7);
    gate_pin[1] = 1'b0; ticks(4);
    rd16(1, v); chk("R5 gate low holds", v, 7);

    // R9 split mode
    wr(3'd0, 8'h33, 0);
    wr(3'd4, 8'h34, 0); wr(3'd5, 8'h12, 0);
    wr(3'd2, 8'hFE, 0); wr(3'd3, 8'hFD, 0);
    wr(3'd1, 8'h03, 0);
    ticks(3);
    rd(3'd2, v); chk("R9 split low", v, 8'h01);
    rd(3'd3, v); chk("R9 split high", v, 8'h00);
    chk("R9 both flags", int'(ovf_flag), 3);
    rd16(1, v); chk("R9 channel 1 halted", v, 16'h1234);
    wr(3'd1, 8'h02, 0);
    ticks(2);
    rd(3'd2, v); chk("R9 low under run0 only", v, 8'h01);
    rd(3'd3, v); chk("R9 high under run1", v, 8'h02);

    // R10 channel 1 wrap hidden while split
    wr(3'd0, 8'h13, 0);
    wr(3'd4, 8'hFF, 0); wr(3'd5, 8'hFF, 0);
    wr(3'd2, 8'h00, 0); wr(3'd3, 8'h00, 0);
    wr(3'd1, 8'h02, 0);
    ticks(1);
    rd16(1, v); chk("R10 channel 1 wrapped", v, 0);
    chk("R10 flag1 untouched", int'(ovf_flag[1]), 0);
    wr(3'd3, 8'hFF, 0);
    ticks(1);
    chk("R10 flag1 from split high", int'(ovf_flag[1]), 1);

    // R12 write priority
    wr(3'd0, 8'h11, 0);
    wr(3'd1, 8'h01, 0);
    wr(3'd2, 8'h10, 0); wr(3'd3, 8'h00, 0);
    wr(3'd2, 8'h55, 1);
    rd16(0, v); chk("R12 low write beats step", v, 16'h0055);
    wr(3'd2, 8'hFF, 0);
    wr(3'd3, 8'h40, 1);
    rd16(0, v); chk("R12 high write cancels step", v, 16'h40FF);
    wr(3'd0, 8'h12, 0);
    wr(3'd1, 8'h01, 0);
    wr(3'd2, 8'hFF, 0); wr(3'd3, 8'h20, 0);
    wr(3'd3, 8'h30, 1);
    rd16(0, v); chk("R12 reload uses old high", v, 16'h3020);
    chk("R12 flag on reload", int'(ovf_flag[0]), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule